// File: doc/BRIEF.md
# Four-Level Strided DMA Address Generator

This block turns one transfer record into the ordered list of start addresses for the element runs of a DMA move. A record holds up to four nested loop counts. The innermost count is the length in bytes of one contiguous run. Each of the three outer levels has a count and a signed stride. The generator issues one beat per innermost run. Beats start at the innermost level and work outward. Each beat carries the run's start address, its byte length and a flag on the final beat of the record.

Two trigger slots can hold progress back. The record's flags name a source for each slot and the loop level that one pulse releases. A separate flag field picks the progress point at which a one-cycle event pulse is raised. When the chosen loop level is absent from the record, the event falls back to the end of the transfer. A wait flag controls whether the next record can be taken in the cycle in which `done` is high or only after that cycle.

Top module: `tr4_agen`

## Requirements
- R1: After reset, `rec_ready` is 1 and `beat_valid`, `done` and `evt` are 0.
- R2: `rec_flags[3:0]` is the record kind. A value of 0, 1 or 2 gives 1, 2 or 3 loop levels, and any value of 3 or more gives 4 levels. The counts of absent levels are ignored and treated as 1.
- R3: Beats come in loop order, level 1 varying fastest. The beat address is `base + i1*str1 + i2*str2 + i3*str3`, computed with sign-extended strides in 64-bit wrapping arithmetic. `beat_len` equals count 0, and `beat_last` is 1 only on the final beat.
- R4: While `beat_valid` is 1 and `beat_ready` is 0, the beat's address, length and last flag hold steady.
- R5: `done` is 1 for exactly the one cycle after the final beat is accepted, and `beat_valid` is 0 in that cycle.
- R6: `rec_flags[7:6]` selects the event point. With 0, one `evt` pulse follows acceptance of the final beat. With k in 1..3, a pulse follows every accepted beat that completes one iteration of level k. Each pulse comes in the cycle after the accepted beat.
- R7: When the level chosen by `rec_flags[7:6]` is absent from the record, exactly one `evt` pulse is raised, in the cycle after the final beat is accepted.
- R8: Slot A uses source select `rec_flags[9:8]` and scope `[11:10]`. Slot B uses source select `[13:12]` and scope `[15:14]`. A source select of 0 disables the slot, 1 selects `trig_glb[0]`, 2 selects `trig_glb[1]` and 3 selects `trig_loc`. A scope of 0, 1 or 2 lets one pulse release beats until one iteration of level 1, 2 or 3 completes. A pulse on an unselected source releases nothing.
- R9: A scope of 3 lets one pulse release the whole record. Pulses that arrive while a slot is already released, or while no record is running, are discarded.
- R10: When wait flag `rec_flags[5]` is 1, `rec_ready` is 0 in the cycle in which `done` is high. When it is 0, `rec_ready` is 1 in that cycle. `rec_ready` is never 1 while a beat is offered.
- R11: If count 0 or the count of any present level is zero, the record issues no beats and `done` rises in the cycle after the record is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_valid | input | 1 | A record is offered |
| rec_ready | output | 1 | A record can be accepted |
| rec_flags | input | 16 | Kind, wait, event point and trigger fields |
| rec_base | input | 64 | Start address |
| rec_cnt0 | input | 16 | Innermost byte count |
| rec_cnt1 | input | 16 | Level 1 count |
| rec_cnt2 | input | 16 | Level 2 count |
| rec_cnt3 | input | 16 | Level 3 count |
| rec_str1 | input | 32 | Level 1 signed stride |
| rec_str2 | input | 32 | Level 2 signed stride |
| rec_str3 | input | 32 | Level 3 signed stride |
| trig_glb | input | 2 | Global trigger pulses 0 and 1 |
| trig_loc | input | 1 | Local trigger pulse |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | Downstream takes the beat |
| beat_addr | output | 64 | Run start address |
| beat_len | output | 16 | Run length in bytes |
| beat_last | output | 1 | Final beat of the record |
| evt | output | 1 | Progress event pulse |
| done | output | 1 | Record completion pulse |

## Verification
The assertions check on every cycle that a stalled beat is held steady, that `done` follows the final accepted beat and never an earlier one, that no beat is offered while a record can be taken, and that each event pulse follows an accepted beat. Only the scenarios can show the address sequence itself, with negative strides and ignored counts. The same holds for how many events each event point produces and for the fallback to end of transfer. The trigger gating has to be shown by scenarios too: one decrement per pulse, the dropped pulses and the unselected sources. So do the wait flag and the zero-count case.

// File: rtl/tr4_pkg.sv
package tr4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } tr4_state_e;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_GLB0  = 2'd1,
    SRC_GLB1  = 2'd2,
    SRC_LOCAL = 2'd3
  } tr4_src_e;

  // packed view of the 16 record flag bits, msb first
  typedef struct packed {
    logic [1:0] scope_b;
    logic [1:0] src_b;
    logic [1:0] scope_a;
    logic [1:0] src_a;
    logic [1:0] evsel;
    logic       hold;
    logic       rsvd;
    logic [3:0] kind;
  } tr4_flags_t;

  localparam int unsigned OUTER_LVLS = 3;
  localparam int unsigned TRIG_SLOTS = 2;
endpackage

// File: rtl/tr4_loopctl.sv
module tr4_loopctl #(
  parameter int CNT_W = 16,
  parameter int NL    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic                      step,
  input  logic [NL-1:0][CNT_W-1:0]  n_in,
  output logic [NL-1:0]             last
);
  logic [NL-1:0] carry;
  assign carry[0] = step;

  for (genvar j = 0; j < NL; j++) begin : g_lvl
    logic [CNT_W-1:0] n_q, n_d, i_q, i_d;

    assign last[j] = (i_q == n_q - 1'b1);

    if (j < NL - 1) begin : g_carry
      assign carry[j+1] = carry[j] & last[j];
    end

    always_comb begin
      n_d = n_q;
      i_d = i_q;
      if (load) begin
        n_d = n_in[j];
        i_d = '0;
      end else if (carry[j]) begin
        i_d = last[j] ? '0 : i_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        n_q <= '0;
        i_q <= '0;
      end else if (load || carry[j]) begin
        n_q <= n_d;
        i_q <= i_d;
      end
    end
  end
endmodule

// File: rtl/tr4_addrgen.sv
module tr4_addrgen #(
  parameter int ADDR_W = 64,
  parameter int STR_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic [ADDR_W-1:0]       base,
  input  logic [2:0][STR_W-1:0]   str_in,
  input  logic [1:0]              last,
  output logic [ADDR_W-1:0]       addr
);
  logic [ADDR_W-1:0]     cur_q, cur_d, p2_q, p2_d, p3_q, p3_d;
  logic [2:0][STR_W-1:0] str_q, str_d;

  function automatic logic [ADDR_W-1:0] sx(input logic [STR_W-1:0] s);
    return {{(ADDR_W-STR_W){s[STR_W-1]}}, s};
  endfunction

  always_comb begin
    cur_d = cur_q;
    p2_d  = p2_q;
    p3_d  = p3_q;
    str_d = str_q;
    if (load) begin
      cur_d = base;
      p2_d  = base;
      p3_d  = base;
      str_d = str_in;
    end else if (step) begin
      if (!last[0]) begin
        cur_d = cur_q + sx(str_q[0]);
      end else if (!last[1]) begin
        p2_d  = p2_q + sx(str_q[1]);
        cur_d = p2_d;
      end else begin
        p3_d  = p3_q + sx(str_q[2]);
        p2_d  = p3_d;
        cur_d = p3_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      p2_q  <= '0;
      p3_q  <= '0;
      str_q <= '0;
    end else if (load || step) begin
      cur_q <= cur_d;
      p2_q  <= p2_d;
      p3_q  <= p3_d;
      str_q <= str_d;
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/tr4_gate.sv
module tr4_gate
  import tr4_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] src,
  input  logic [1:0] scope,
  input  logic [1:0] glb,
  input  logic       loc,
  input  logic [3:1] dec,
  input  logic [3:1] pres,
  input  logic       fin_acc,
  output logic       pass
);
  logic open_q, open_d, pulse, close;

  always_comb begin
    case (tr4_src_e'(src))
      SRC_GLB0:  pulse = glb[0];
      SRC_GLB1:  pulse = glb[1];
      SRC_LOCAL: pulse = loc;
      default:   pulse = 1'b0;
    endcase
  end

  always_comb begin
    case (scope)
      2'd0:    close = pres[1] ? dec[1] : fin_acc;
      2'd1:    close = pres[2] ? dec[2] : fin_acc;
      2'd2:    close = pres[3] ? dec[3] : fin_acc;
      default: close = fin_acc;
    endcase
  end

  always_comb begin
    open_d = open_q;
    if (clr)                        open_d = 1'b0;
    else if (open_q && close)       open_d = 1'b0;
    else if (!open_q && run && pulse) open_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  assign pass = (src == 2'd0) || open_q;
endmodule

// File: rtl/tr4_agen.sv
module tr4_agen
  import tr4_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16,
  parameter int STR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [15:0]       rec_flags,
  input  logic [ADDR_W-1:0] rec_base,
  input  logic [CNT_W-1:0]  rec_cnt0,
  input  logic [CNT_W-1:0]  rec_cnt1,
  input  logic [CNT_W-1:0]  rec_cnt2,
  input  logic [CNT_W-1:0]  rec_cnt3,
  input  logic [STR_W-1:0]  rec_str1,
  input  logic [STR_W-1:0]  rec_str2,
  input  logic [STR_W-1:0]  rec_str3,
  input  logic [1:0]        trig_glb,
  input  logic              trig_loc,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [CNT_W-1:0]  beat_len,
  output logic              beat_last,
  output logic              evt,
  output logic              done
);
  localparam int NL = OUTER_LVLS;
  localparam int NS = TRIG_SLOTS;

  tr4_flags_t fl;
  tr4_state_e state_q, state_d;
  logic [3:1] pres_in, pres_q;
  logic [1:0] evsel_q;
  logic       hold_q;
  logic [NS-1:0][1:0] src_q, scope_q;
  logic [CNT_W-1:0] len_q;
  logic       evt_q, evt_d;

  logic load, accept, final_b, fin_acc, running, zero_in;
  logic [NL-1:0] last;
  logic [3:1] dec;
  logic [NL-1:0][CNT_W-1:0] n_in;
  logic [NS-1:0] pass;

  assign fl      = tr4_flags_t'(rec_flags);
  assign pres_in = {fl.kind >= 4'd3, fl.kind >= 4'd2, fl.kind >= 4'd1};
  assign n_in[0] = pres_in[1] ? rec_cnt1 : CNT_W'(1);
  assign n_in[1] = pres_in[2] ? rec_cnt2 : CNT_W'(1);
  assign n_in[2] = pres_in[3] ? rec_cnt3 : CNT_W'(1);
  assign zero_in = (rec_cnt0 == '0) || (n_in[0] == '0) ||
                   (n_in[1] == '0) || (n_in[2] == '0);

  assign running   = (state_q == ST_RUN);
  assign rec_ready = (state_q == ST_IDLE) || ((state_q == ST_FIN) && !hold_q);
  assign load      = rec_valid && rec_ready;
  assign beat_valid = running && (&pass);
  assign accept    = beat_valid && beat_ready;
  assign final_b   = &last;
  assign fin_acc   = accept && final_b;
  assign dec       = {accept && last[0] && last[1], accept && last[0], accept};

  tr4_loopctl #(.CNT_W(CNT_W), .NL(NL)) u_loop (
    .clk(clk), .rst_n(rst_n), .load(load), .step(accept),
    .n_in(n_in), .last(last)
  );

  tr4_addrgen #(.ADDR_W(ADDR_W), .STR_W(STR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .step(accept),
    .base(rec_base), .str_in({rec_str3, rec_str2, rec_str1}),
    .last(last[1:0]), .addr(beat_addr)
  );

  for (genvar g = 0; g < NS; g++) begin : g_slot
    tr4_gate u_gate (
      .clk(clk), .rst_n(rst_n), .clr(load), .run(running),
      .src(src_q[g]), .scope(scope_q[g]), .glb(trig_glb), .loc(trig_loc),
      .dec(dec), .pres(pres_q), .fin_acc(fin_acc), .pass(pass[g])
    );
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN:  if (fin_acc) state_d = ST_FIN;
      default: begin
        if (load)                   state_d = zero_in ? ST_FIN : ST_RUN;
        else if (state_q == ST_FIN) state_d = ST_IDLE;
      end
    endcase
  end

  always_comb begin
    case (evsel_q)
      2'd0:    evt_d = fin_acc;
      2'd1:    evt_d = pres_q[1] ? dec[1] : fin_acc;
      2'd2:    evt_d = pres_q[2] ? dec[2] : fin_acc;
      default: evt_d = pres_q[3] ? dec[3] : fin_acc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q  <= '0;
      evsel_q <= '0;
      hold_q  <= 1'b0;
      src_q   <= '0;
      scope_q <= '0;
      len_q   <= '0;
    end else if (load) begin
      pres_q  <= pres_in;
      evsel_q <= fl.evsel;
      hold_q  <= fl.hold;
      src_q   <= {fl.src_b, fl.src_a};
      scope_q <= {fl.scope_b, fl.scope_a};
      len_q   <= rec_cnt0;
    end
  end

  assign beat_len  = len_q;
  assign beat_last = final_b;
  assign evt       = evt_q;
  assign done      = (state_q == ST_FIN);
endmodule

// File: rtl/tr4_agen_chk.sv
module tr4_agen_chk #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec_ready,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [CNT_W-1:0]  beat_len,
  input logic              beat_last,
  input logic              evt,
  input logic              done
);
  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
    $stable(beat_len) && $stable(beat_last));

  // R5
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> done && !beat_valid);

  // R5
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && !beat_last |=> !done);

  // R10
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |-> !beat_valid);

  // R6
  evt_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(beat_valid && beat_ready));
endmodule

bind tr4_agen tr4_agen_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_ready(rec_ready), .beat_valid(beat_valid),
  .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_len(beat_len),
  .beat_last(beat_last), .evt(evt), .done(done)
);

// File: tb/sim_tr4_agen.sv
module sim_tr4_agen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rec_valid = 1'b0;
  logic rec_ready;
  logic [15:0] rec_flags = '0;
  logic [63:0] rec_base = '0;
  logic [15:0] rec_cnt0 = '0, rec_cnt1 = '0, rec_cnt2 = '0, rec_cnt3 = '0;
  logic [31:0] rec_str1 = '0, rec_str2 = '0, rec_str3 = '0;
  logic [1:0]  trig_glb = '0;
  logic        trig_loc = 1'b0;
  logic        beat_valid, beat_last, evt, done;
  logic        beat_ready = 1'b1;
  logic [63:0] beat_addr;
  logic [15:0] beat_len;

  int n_chk = 0, n_fail = 0, evt_cnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tr4_agen u0 (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_flags(rec_flags), .rec_base(rec_base), .rec_cnt0(rec_cnt0),
    .rec_cnt1(rec_cnt1), .rec_cnt2(rec_cnt2), .rec_cnt3(rec_cnt3),
    .rec_str1(rec_str1), .rec_str2(rec_str2), .rec_str3(rec_str3),
    .trig_glb(trig_glb), .trig_loc(trig_loc), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .beat_addr(beat_addr), .beat_len(beat_len),
    .beat_last(beat_last), .evt(evt), .done(done)
  );

  always @(negedge clk) if (rst_n && evt) evt_cnt++;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mkf(input int kind, input int hold, input int evs,
                                      input int sa, input int ta, input int sb, input int tb);
    return {2'(tb), 2'(sb), 2'(ta), 2'(sa), 2'(evs), 1'(hold), 1'b0, 4'(kind)};
  endfunction

  task automatic load_rec(input logic [15:0] f, input logic [63:0] base,
                          input int c0, input int c1, input int c2, input int c3,
                          input int s1, input int s2, input int s3);
    rec_flags = f; rec_base = base;
    rec_cnt0 = 16'(c0); rec_cnt1 = 16'(c1); rec_cnt2 = 16'(c2); rec_cnt3 = 16'(c3);
    rec_str1 = 32'(s1); rec_str2 = 32'(s2); rec_str3 = 32'(s3);
    evt_cnt = 0;
    chk(rec_ready === 1'b1, "R10", "ready before load", longint'(rec_ready), 1);
    rec_valid = 1'b1;
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic run_rec(input logic [15:0] f, input logic [63:0] base,
                         input int c0, input int c1, input int c2, input int c3,
                         input int s1, input int s2, input int s3,
                         input bit stall, input string rq);
    int rt, n1, n2, n3, ev, exp_ev;
    bit wt;
    rt = int'(f[3:0]); ev = int'(f[7:6]); wt = f[5];
    n1 = (rt >= 1) ? c1 : 1;
    n2 = (rt >= 2) ? c2 : 1;
    n3 = (rt >= 3) ? c3 : 1;
    case (ev)
      0:       exp_ev = 1;
      1:       exp_ev = (rt >= 1) ? n1 * n2 * n3 : 1;
      2:       exp_ev = (rt >= 2) ? n2 * n3 : 1;
      default: exp_ev = (rt >= 3) ? n3 : 1;
    endcase
    load_rec(f, base, c0, c1, c2, c3, s1, s2, s3);
    for (int i3 = 0; i3 < n3; i3++)
      for (int i2 = 0; i2 < n2; i2++)
        for (int i1 = 0; i1 < n1; i1++) begin
          longint ea;
          bit el;
          ea = longint'(base) + longint'(i1) * longint'(s1) +
               longint'(i2) * longint'(s2) + longint'(i3) * longint'(s3);
          el = (i1 == n1 - 1) && (i2 == n2 - 1) && (i3 == n3 - 1);
          chk(beat_valid === 1'b1 && beat_addr === 64'(ea) && beat_len === 16'(c0) &&
              beat_last === el, rq, "beat address", longint'(beat_addr), ea);
          if (stall) begin
            beat_ready = 1'b0;
            @(negedge clk);
            chk(beat_valid === 1'b1 && beat_addr === 64'(ea) && beat_last === el,
                "R4", "stalled beat", longint'(beat_addr), ea);
            beat_ready = 1'b1;
          end
          @(negedge clk);
        end
    chk(done === 1'b1 && beat_valid === 1'b0, "R5", "done after last", longint'(done), 1);
    chk(rec_ready === !wt, "R10", "ready in done cycle", longint'(rec_ready), longint'(!wt));
    @(negedge clk);
    chk(done === 1'b0 && rec_ready === 1'b1, "R5", "done one cycle", longint'(done), 0);
    chk(evt_cnt == exp_ev, (ev != 0 && rt < ev) ? "R7" : "R6", "event count",
        longint'(evt_cnt), longint'(exp_ev));
  endtask

  task automatic test_reset;
    chk(rec_ready === 1'b1 && beat_valid === 1'b0 && done === 1'b0 && evt === 1'b0,
        "R1", "reset state", longint'({rec_ready, beat_valid, done, evt}), 8);
  endtask

  task automatic test_zero;
    load_rec(mkf(2, 0, 0, 0, 0, 0, 0), 64'h40, 32, 3, 0, 1, 4, 8, 0);
    chk(done === 1'b1 && beat_valid === 1'b0, "R11", "zero count done", longint'(done), 1);
    @(negedge clk);
    chk(done === 1'b0 && beat_valid === 1'b0, "R11", "zero count idle", longint'(beat_valid), 0);
  endtask

  task automatic pulse_glb(input logic [1:0] v);
    trig_glb = v;
    @(negedge clk);
    trig_glb = 2'b00;
  endtask

  task automatic test_trig_l1;
    longint ea;
    load_rec(mkf(1, 0, 0, 1, 0, 0, 0), 64'h1000, 4, 3, 0, 0, 'h10, 'h100, 0);
    chk(beat_valid === 1'b0, "R8", "gated at start", longint'(beat_valid), 0);
    pulse_glb(2'b10);
    chk(beat_valid === 1'b0, "R8", "unselected source", longint'(beat_valid), 0);
    for (int b = 0; b < 3; b++) begin
      ea = 64'h1000 + longint'(b) * 'h10;
      pulse_glb(2'b01);
      chk(beat_valid === 1'b1 && beat_addr === 64'(ea), "R8", "released beat",
          longint'(beat_addr), ea);
      if (b == 0) begin
        beat_ready = 1'b0;
        pulse_glb(2'b01);
        chk(beat_valid === 1'b1, "R4", "held while open", longint'(beat_valid), 1);
        beat_ready = 1'b1;
      end
      @(negedge clk);
      if (b < 2) chk(beat_valid === 1'b0, "R9", "one beat per pulse", longint'(beat_valid), 0);
      else       chk(done === 1'b1, "R5", "trigger record done", longint'(done), 1);
    end
    @(negedge clk);
  endtask

  task automatic test_trig_l2;
    load_rec(mkf(2, 0, 0, 0, 0, 2, 1), 64'h2000, 8, 2, 2, 0, 4, 'h40, 0);
    chk(beat_valid === 1'b0, "R8", "level2 gated", longint'(beat_valid), 0);
    for (int g = 0; g < 2; g++) begin
      pulse_glb(2'b10);
      chk(beat_valid === 1'b1 && beat_addr === 64'h2000 + 64'(g * 'h40), "R8",
          "level2 first", longint'(beat_addr), 'h2000 + g * 'h40);
      @(negedge clk);
      chk(beat_valid === 1'b1 && beat_addr === 64'h2004 + 64'(g * 'h40), "R8",
          "level2 second", longint'(beat_addr), 'h2004 + g * 'h40);
      @(negedge clk);
      if (g == 0) chk(beat_valid === 1'b0, "R8", "level2 closes", longint'(beat_valid), 0);
      else        chk(done === 1'b1, "R5", "level2 done", longint'(done), 1);
    end
    @(negedge clk);
  endtask

  task automatic test_trig_all;
    trig_loc = 1'b1;
    @(negedge clk);
    trig_loc = 1'b0;
    load_rec(mkf(2, 0, 0, 3, 3, 0, 0), 64'h3000, 2, 2, 3, 9, 8, 'h80, 'h7000);
    chk(beat_valid === 1'b0, "R9", "idle pulse dropped", longint'(beat_valid), 0);
    @(negedge clk);
    chk(beat_valid === 1'b0, "R9", "still gated", longint'(beat_valid), 0);
    trig_loc = 1'b1;
    @(negedge clk);
    trig_loc = 1'b0;
    for (int k = 0; k < 6; k++) begin
      longint ea;
      ea = 'h3000 + (k % 2) * 8 + (k / 2) * 'h80;
      chk(beat_valid === 1'b1 && beat_addr === 64'(ea), "R9", "whole record flows",
          longint'(beat_addr), ea);
      @(negedge clk);
    end
    chk(done === 1'b1, "R9", "whole record done", longint'(done), 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    // R3 four levels, negative outer stride, level-2 events
    run_rec(mkf(3, 0, 2, 0, 0, 0, 0), 64'h0000_8000_0000_0000, 64, 2, 3, 2,
            'h40, 'h400, -'h2000, 0, "R3");
    // R2 two levels, absent counts ignored, stalls, wait flag
    run_rec(mkf(1, 1, 1, 0, 0, 0, 0), 64'h100, 8, 4, 5, 5, -8, 'h20, 'h30, 1, "R2");
    run_rec(mkf(0, 0, 1, 0, 0, 0, 0), 64'h500, 12, 7, 7, 7, 4, 4, 4, 0, "R7");
    run_rec(mkf(1, 0, 2, 0, 0, 0, 0), 64'h600, 16, 3, 9, 9, 16, 4, 4, 0, "R7");
    run_rec(mkf(2, 0, 3, 0, 0, 0, 0), 64'h700, 16, 2, 2, 9, 16, 64, 4, 0, "R7");
    run_rec(mkf(7, 0, 3, 0, 0, 0, 0), 64'h10_0000, 32, 2, 2, 3, 32, 'h100, 'h1000, 0, "R2");
    run_rec(mkf(2, 0, 0, 0, 0, 0, 0), 64'hFFFF_FFFF_FFFF_FFF0, 4, 2, 2, 1, 8, 'h10, 0, 0, "R6");
    test_zero();
    test_trig_l1();
    test_trig_l2();
    test_trig_all();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule